// File: doc/BRIEF.md
# Center-Spread Triangular Modulation Profile Generator

This block produces the digital offset code that steers a frequency synthesizer through a symmetric triangular sweep around its nominal frequency. The sweep is centered, so the offset goes above and below zero by equal amounts. The peak magnitude is one of two fixed depths. The offset is given in fixed-point units of 0.0625 %. Depth select 0 gives a peak of 4 units (plus or minus 0.25 %). Depth select 1 gives a peak of 8 units (plus or minus 0.5 %).

State advances only on a single-cycle step tick. The rising half of the sweep and the falling half each take their own 4-bit step count. That count is the number of ticks the ramp needs to travel from zero offset to an extreme. On each tick the offset equals the peak scaled by the ratio of the current position to the active count, truncated toward zero. The sweep starts at zero and rises first. Clearing the enable parks the output at zero offset.

Top module: `ssm_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `ofs` is 0 and `dir_up` is 0.
- R2: `ofs` and `dir_up` change only in the cycle that follows a clock edge at which `step_tick` is 1.
- R3: A tick with `ss_en`=1 while the block is idle starts the sweep: `ofs` becomes 0 and `dir_up` becomes 1.
- R4: While rising, each tick moves the position p up by one. `ofs` = trunc(P·p/N), where N is the latched rising count and P is 4 for `depth_sel`=0 or 8 for `depth_sel`=1. At p = N the output reaches +P.
- R5: The tick after the positive extreme sets `dir_up` to 0 and restarts the position at N_dn−1 on the falling scale. The fall continues through zero to −P at position −N_dn. The next tick turns the sweep upward again at position −N_up+1.
- R6: A count field of 0 behaves as a count of 1. With both counts 0 the output repeats 0, +P, 0, −P.
- R7: A tick with `ss_en`=0 returns `ofs` to 0 and `dir_up` to 0. From idle, such a tick keeps both at 0.
- R8: Changes to `up_cnt`, `dn_cnt` or `depth_sel` during a sweep take effect only at the next turnaround, or at the next start from idle.
- R9: The magnitude of `ofs` never exceeds the latched peak, and never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ss_en | input | 1 | Modulation enable, sampled on ticks |
| depth_sel | input | 1 | Peak depth: 0 → 4 units, 1 → 8 units |
| up_cnt | input | 4 | Ticks from center to positive extreme (0 acts as 1) |
| dn_cnt | input | 4 | Ticks from center to negative extreme (0 acts as 1) |
| step_tick | input | 1 | Single-cycle advance strobe |
| ofs | output | 5 | Signed offset, units of 0.0625 % |
| dir_up | output | 1 | 1 while the ramp is rising |

## Verification
A corrupted position or direction register shows up on the very next tick as an offset that breaks monotonic order, or as a turnaround at the wrong value. The scoreboard compares every tick, so such a fault is caught within one step. A wrong latched count or depth changes the slope of the ramp. It is seen within a few ticks as a wrong truncated quotient, most clearly at non-dividing counts such as 3. Faults in the idle and disable paths show up as a nonzero offset one tick after enable is cleared.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic {
    SSM_IDLE = 1'b0,
    SSM_RUN  = 1'b1
  } ssm_state_e;
endpackage

// File: rtl/ssm_rst_sync.sv
module ssm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ssm_div.sv
module ssm_div #(
  parameter int NUM_W = 9,
  parameter int DEN_W = 5
) (
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo
);
  logic [NUM_W:0][DEN_W-1:0] rem;

  assign rem[0] = '0;

  for (genvar i = 0; i < NUM_W; i++) begin : g_stage
    logic [DEN_W:0] trial;
    logic           ge;
    assign trial = {rem[i], num[NUM_W-1-i]};
    assign ge    = trial >= {1'b0, den};
    assign quo[NUM_W-1-i] = ge;
    assign rem[i+1] = ge ? DEN_W'(trial - {1'b0, den}) : DEN_W'(trial);
  end
endmodule

// File: rtl/ssm_scale.sv
module ssm_scale #(
  parameter int CNT_W = 4,
  parameter int PK_W  = 4,
  localparam int N_W    = CNT_W + 1,
  localparam int T_W    = CNT_W + 2,
  localparam int OFS_W  = PK_W + 1,
  localparam int PROD_W = PK_W + N_W
) (
  input  logic signed [T_W-1:0]   pos,
  input  logic        [N_W-1:0]   span,
  input  logic        [PK_W-1:0]  peak,
  output logic signed [OFS_W-1:0] ofs
);
  logic [N_W-1:0]    mag;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quo;
  logic [OFS_W-1:0]  quo_s;

  always_comb begin
    mag  = (pos < 0) ? N_W'(-pos) : N_W'(pos);
    prod = PROD_W'(peak) * PROD_W'(mag);
  end

  ssm_div #(.NUM_W(PROD_W), .DEN_W(N_W)) u_div (
    .num (prod),
    .den (span),
    .quo (quo)
  );

  always_comb begin
    quo_s = OFS_W'(quo);
    ofs   = (pos < 0) ? -$signed(quo_s) : $signed(quo_s);
  end
endmodule

// File: rtl/ssm_seq.sv
module ssm_seq
  import ssm_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int PK_W     = 4,
  parameter int DEPTH_LO = 4,
  parameter int DEPTH_HI = 8,
  localparam int N_W = CNT_W + 1,
  localparam int T_W = CNT_W + 2
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  ss_en,
  input  logic                  depth_sel,
  input  logic [CNT_W-1:0]      up_cnt,
  input  logic [CNT_W-1:0]      dn_cnt,
  input  logic                  step_tick,
  output logic                  run_q,
  output logic                  dir_q,
  output logic [PK_W-1:0]       pk_q,
  output logic                  dir_nxt,
  output logic signed [T_W-1:0] t_nxt,
  output logic [N_W-1:0]        n_nxt,
  output logic [PK_W-1:0]       pk_nxt
);
  ssm_state_e            state_q, state_nxt;
  logic signed [T_W-1:0] t_q;
  logic [N_W-1:0]        n_q;
  logic [N_W-1:0]        up_eff, dn_eff;
  logic [PK_W-1:0]       pk_sel;
  logic signed [T_W-1:0] n_s;

  always_comb begin
    up_eff = (up_cnt == '0) ? N_W'(1) : {1'b0, up_cnt};
    dn_eff = (dn_cnt == '0) ? N_W'(1) : {1'b0, dn_cnt};
    pk_sel = depth_sel ? PK_W'(DEPTH_HI) : PK_W'(DEPTH_LO);
    n_s    = $signed({1'b0, n_q});
  end

  always_comb begin
    state_nxt = state_q;
    dir_nxt   = dir_q;
    t_nxt     = t_q;
    n_nxt     = n_q;
    pk_nxt    = pk_q;
    if (step_tick) begin
      if (state_q == SSM_IDLE) begin
        if (ss_en) begin
          state_nxt = SSM_RUN;
          dir_nxt   = 1'b1;
          t_nxt     = '0;
          n_nxt     = up_eff;
          pk_nxt    = pk_sel;
        end
      end else if (!ss_en) begin
        state_nxt = SSM_IDLE;
        dir_nxt   = 1'b0;
        t_nxt     = '0;
      end else if (dir_q) begin
        if (t_q >= n_s) begin
          dir_nxt = 1'b0;
          n_nxt   = dn_eff;
          pk_nxt  = pk_sel;
          t_nxt   = $signed({1'b0, dn_eff}) - T_W'(1);
        end else begin
          t_nxt = t_q + T_W'(1);
        end
      end else begin
        if (t_q <= -n_s) begin
          dir_nxt = 1'b1;
          n_nxt   = up_eff;
          pk_nxt  = pk_sel;
          t_nxt   = T_W'(1) - $signed({1'b0, up_eff});
        end else begin
          t_nxt = t_q - T_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= SSM_IDLE;
      dir_q   <= 1'b0;
      t_q     <= '0;
      n_q     <= N_W'(1);
      pk_q    <= PK_W'(DEPTH_LO);
    end else if (step_tick) begin
      state_q <= state_nxt;
      dir_q   <= dir_nxt;
      t_q     <= t_nxt;
      n_q     <= n_nxt;
      pk_q    <= pk_nxt;
    end
  end

  assign run_q = (state_q == SSM_RUN);
endmodule

// File: rtl/ssm_gen.sv
module ssm_gen #(
  parameter int CNT_W    = 4,
  parameter int DEPTH_LO = 4,
  parameter int DEPTH_HI = 8,
  localparam int PK_W  = $clog2(DEPTH_HI + 1),
  localparam int OFS_W = PK_W + 1,
  localparam int N_W   = CNT_W + 1,
  localparam int T_W   = CNT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ss_en,
  input  logic                    depth_sel,
  input  logic [CNT_W-1:0]        up_cnt,
  input  logic [CNT_W-1:0]        dn_cnt,
  input  logic                    step_tick,
  output logic signed [OFS_W-1:0] ofs,
  output logic                    dir_up
);
  logic                    srst_n;
  logic                    run_q, dir_q, dir_nxt;
  logic [PK_W-1:0]         pk_q, pk_nxt;
  logic signed [T_W-1:0]   t_nxt;
  logic [N_W-1:0]          n_nxt;
  logic signed [OFS_W-1:0] ofs_calc, ofs_d, ofs_q;

  ssm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ssm_seq #(
    .CNT_W(CNT_W), .PK_W(PK_W), .DEPTH_LO(DEPTH_LO), .DEPTH_HI(DEPTH_HI)
  ) u_seq (
    .clk       (clk),
    .srst_n    (srst_n),
    .ss_en     (ss_en),
    .depth_sel (depth_sel),
    .up_cnt    (up_cnt),
    .dn_cnt    (dn_cnt),
    .step_tick (step_tick),
    .run_q     (run_q),
    .dir_q     (dir_q),
    .pk_q      (pk_q),
    .dir_nxt   (dir_nxt),
    .t_nxt     (t_nxt),
    .n_nxt     (n_nxt),
    .pk_nxt    (pk_nxt)
  );

  ssm_scale #(.CNT_W(CNT_W), .PK_W(PK_W)) u_scale (
    .pos  (t_nxt),
    .span (n_nxt),
    .peak (pk_nxt),
    .ofs  (ofs_calc)
  );

  always_comb begin
    ofs_d = step_tick ? ofs_calc : ofs_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ofs_q <= '0;
    else         ofs_q <= ofs_d;
  end

  assign ofs    = ofs_q;
  assign dir_up = dir_q & run_q;

  logic unused_dir_nxt;
  assign unused_dir_nxt = dir_nxt;
endmodule

// File: rtl/ssm_gen_chk.sv
module ssm_gen_chk #(
  parameter int DEPTH_HI = 8,
  parameter int PK_W     = 4,
  parameter int OFS_W    = 5
) (
  input logic                    clk,
  input logic                    srst_n,
  input logic                    ss_en,
  input logic                    step_tick,
  input logic                    run_q,
  input logic [PK_W-1:0]         pk_q,
  input logic signed [OFS_W-1:0] ofs,
  input logic                    dir_up
);
  logic signed [OFS_W:0] pk_s, ofs_w;
  assign pk_s  = $signed({1'b0, pk_q});
  assign ofs_w = OFS_W'(ofs);

  always @(posedge clk) begin
    if (!srst_n) assert_reset_R1: assert (ofs == 0 && !dir_up);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !step_tick |=> ($stable(ofs) && $stable(dir_up)));

  assert_start_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (step_tick && ss_en && !run_q) |=> (ofs == 0 && dir_up));

  assert_rise_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (step_tick && ss_en && run_q && dir_up && ofs_w != pk_s) |=> (ofs >= $past(ofs)));

  assert_turn_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (step_tick && ss_en && run_q && dir_up && ofs_w == pk_s) |=> !dir_up);

  assert_stop_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (step_tick && !ss_en) |=> (ofs == 0 && !dir_up));

  assert_bound_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (ofs_w <= pk_s && ofs_w >= -pk_s && ofs_w <= DEPTH_HI));
endmodule

bind ssm_gen ssm_gen_chk #(.DEPTH_HI(DEPTH_HI), .PK_W(PK_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .ss_en     (ss_en),
  .step_tick (step_tick),
  .run_q     (run_q),
  .pk_q      (pk_q),
  .ofs       (ofs),
  .dir_up    (dir_up)
);

// File: tb/ssm_gen_bench.sv
module ssm_gen_bench;
  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ss_en, depth_sel, step_tick;
  logic [3:0]        up_cnt, dn_cnt;
  logic signed [4:0] ofs;
  logic              dir_up;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int    q_ofs[$];
  int    q_dir[$];
  string q_tag[$];

  int m_run = 0, m_dir = 0, m_t = 0, m_n = 1, m_pk = 4;

  always #(CLK_P/2) clk = ~clk;

  ssm_gen u_ssm_gen (
    .clk(clk), .rst_n(rst_n), .ss_en(ss_en), .depth_sel(depth_sel),
    .up_cnt(up_cnt), .dn_cnt(dn_cnt), .step_tick(step_tick),
    .ofs(ofs), .dir_up(dir_up)
  );

  task automatic check(input string tag, input int act_o, input int act_d,
                       input int exp_o, input int exp_d);
    n_chk++;
    if (act_o != exp_o || act_d != exp_d) begin
      n_fail++;
      $display("FAIL %s: actual ofs=%0d dir=%0d expected ofs=%0d dir=%0d",
               tag, act_o, act_d, exp_o, exp_d);
    end
  endtask

  // Driver: advance the reference sweep, queue the expectation, pulse the tick
  task automatic do_tick(input bit en, input bit dsel, input int up, input int dn,
                         input string tag);
    int eu, ed, p, e;
    eu = (up == 0) ? 1 : up;
    ed = (dn == 0) ? 1 : dn;
    p  = dsel ? 8 : 4;
    if (m_run == 0) begin
      if (en) begin m_run = 1; m_dir = 1; m_t = 0; m_n = eu; m_pk = p; end
    end else if (!en) begin
      m_run = 0; m_dir = 0; m_t = 0;
    end else if (m_dir == 1) begin
      if (m_t >= m_n) begin m_dir = 0; m_n = ed; m_pk = p; m_t = ed - 1; end
      else m_t++;
    end else begin
      if (m_t <= -m_n) begin m_dir = 1; m_n = eu; m_pk = p; m_t = 1 - eu; end
      else m_t--;
    end
    if (m_run == 0) e = 0;
    else if (m_t < 0) e = -((m_pk * (-m_t)) / m_n);
    else e = (m_pk * m_t) / m_n;
    q_ofs.push_back(e);
    q_dir.push_back(m_run == 1 ? m_dir : 0);
    q_tag.push_back(tag);
    @(negedge clk);
    ss_en = en; depth_sel = dsel; up_cnt = 4'(up); dn_cnt = 4'(dn);
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
  endtask

  // Monitor: compare after each tick edge
  initial begin
    forever begin
      @(posedge clk);
      if (step_tick === 1'b1) begin
        #(CLK_P/4);
        if (q_ofs.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2: actual output update with empty queue, expected none");
        end else begin
          check(q_tag.pop_front(), int'(ofs), int'(dir_up), q_ofs.pop_front(), q_dir.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h_o, h_d;
    rst_n = 1'b0; ss_en = 0; depth_sel = 0; up_cnt = 0; dn_cnt = 0; step_tick = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", int'(ofs), int'(dir_up), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(ofs), int'(dir_up), 0, 0);
    repeat (3) @(negedge clk);

    do_tick(0, 0, 3, 2, "R7 idle no enable");
    do_tick(1, 0, 3, 2, "R3 start");
    for (int i = 0; i < 3; i++) do_tick(1, 0, 3, 2, "R4 rise depth0");
    for (int i = 0; i < 4; i++) do_tick(1, 0, 3, 2, "R5 fall");
    for (int i = 0; i < 4; i++) do_tick(1, 0, 3, 2, "R5 turn up");

    h_o = int'(ofs); h_d = int'(dir_up);
    repeat (6) @(negedge clk);
    check("R2 hold without tick", int'(ofs), int'(dir_up), h_o, h_d);

    do_tick(1, 0, 3, 2, "R4 resume");
    do_tick(0, 0, 3, 2, "R7 disable mid sweep");
    do_tick(0, 0, 3, 2, "R7 stays idle");

    for (int i = 0; i < 10; i++) do_tick(1, 1, 0, 0, "R6 zero counts");
    do_tick(0, 1, 0, 0, "R7 stop");

    do_tick(1, 1, 5, 3, "R3 restart depth1");
    do_tick(1, 1, 5, 3, "R4 rise");
    for (int i = 0; i < 4; i++) do_tick(1, 0, 2, 7, "R8 late count and depth change");
    for (int i = 0; i < 20; i++) do_tick(1, 0, 2, 7, "R8 applied after turn");
    do_tick(0, 0, 2, 7, "R7 stop");

    do_tick(1, 1, 15, 15, "R3 start full");
    for (int i = 0; i < 64; i++) do_tick(1, 1, 15, 15, "R9 full scale sweep");
    do_tick(0, 1, 15, 15, "R7 final stop");

    repeat (3) @(negedge clk);
    check("R7 parked", int'(ofs), int'(dir_up), 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule